// File: doc/BRIEF.md
# Synchronous Slave-FIFO Read Sequencer

This block is the master side of a synchronous slave-FIFO port. A client hands it a command made of a FIFO address and a word count. The block then drives the FIFO's address, select, output-enable and read-strobe lines in the order the port needs. It collects each word the FIFO releases into a valid/ready output stream.

The address must settle for longer than one clock period. For that reason, the sequencer holds the address and select for a programmable number of cycles before it enables the bus. Output enable comes up one cycle ahead of the strobe, so the word the FIFO has already prefetched is on the bus when the first read edge arrives. A count of one gives a single read. Larger counts give a burst in which the strobe stays high and one word moves per edge.

The strobe drops whenever the output stream is stalled. A raised empty flag ends the transaction early. When a transaction finishes, the block reports how many words actually moved.

Top module: `sfifo_rd_seq`

## Requirements
- R1: While reset is held and right after it, `cmd_ready` is 1 and `fifo_sel`, `fifo_oe`, `fifo_rd`, `out_valid` and `done_valid` are 0.
- R2: After a command is accepted, `fifo_addr` takes `cmd_addr` and `fifo_sel` rises on the same edge. `fifo_oe` then stays low for exactly max(`cfg_setup`,1) cycles with `fifo_sel` high. `cfg_setup` is sampled at acceptance.
- R3: `fifo_rd` is high only while `fifo_oe` is high. Every rising edge of `fifo_rd` follows a cycle in which `fifo_oe` was already high. With the stream ready and the FIFO not empty, the first strobe comes exactly one cycle after `fifo_oe` rises.
- R4: `fifo_rd` is high only while `fifo_sel` is high. `fifo_rd` is low for at least one cycle before `fifo_oe` falls, and `fifo_oe` and `fifo_sel` fall on the same edge.
- R5: In a burst with the stream ready and enough FIFO data, `fifo_rd` stays high for exactly `cmd_count` consecutive cycles. The words appear on `out_data` in FIFO order.
- R6: The word on `fifo_data` at each clock edge where `fifo_rd` is high becomes `out_data` with `out_valid` set. While `out_valid` is 1 and `out_ready` is 0, `out_data` is held, and `fifo_rd` stays low. No word is lost or duplicated.
- R7: A count of 1 gives exactly one strobe cycle. A count of 0 gives no strobe cycle and a `done_count` of 0.
- R8: `fifo_rd` is never high while `fifo_empty` is 1. An empty flag seen during the read phase ends the transaction, and `done_count` equals the words actually read.
- R9: `fifo_addr` does not change on any edge that follows a cycle with `fifo_sel` high. The address therefore stays stable through the cycle after select drops.
- R10: `done_valid` pulses for one cycle, with `fifo_sel` and `fifo_oe` low, carrying the count of words read. `cmd_ready` returns on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | SETUP_W | Address setup cycles (0 treated as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command taken |
| cmd_addr | input | ADDR_W | FIFO address for the command |
| cmd_count | input | CNT_W | Number of words to read |
| fifo_addr | output | ADDR_W | FIFO address to the port |
| fifo_sel | output | 1 | Chip select, active high |
| fifo_oe | output | 1 | Bus output enable, active high |
| fifo_rd | output | 1 | Read strobe, active high |
| fifo_data | input | DATA_W | FIFO data bus |
| fifo_empty | input | 1 | FIFO empty flag, synchronous to clk |
| out_valid | output | 1 | Captured word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | DATA_W | Captured word |
| done_valid | output | 1 | One-cycle end-of-transaction pulse |
| done_count | output | CNT_W | Words read in the finished transaction |

## Verification
The checker assumes that `fifo_empty` is synchronous to `clk` and changes only as a result of the sequencer's own strobes. It also assumes that `fifo_data` shows the prefetched word for the current pointer while output enable is high. The bench's FIFO model enforces this: it advances its pointer only on edges where select and strobe are high and the FIFO is not empty, and it drives the bus from that pointer. Downstream readiness is changed by the bench's own clocked pattern generator and never depends on the sequencer's outputs, so the stall properties see every combination of valid and ready.

// File: rtl/sfifo_rd_pkg.sv
package sfifo_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_OE    = 3'd2,
    ST_READ  = 3'd3,
    ST_RDOFF = 3'd4,
    ST_HOLD  = 3'd5
  } seq_state_e;

endpackage

// File: rtl/sfifo_rd_timer.sv
// Address setup down-counter: loaded on command acceptance, runs in SETUP.
module sfifo_rd_timer #(
  parameter int SETUP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SETUP_W-1:0] load_val,
  input  logic               run,
  output logic               expired
);

  localparam logic [SETUP_W-1:0] ONE = SETUP_W'(1);

  logic [SETUP_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  assign expired = (cnt_q <= ONE);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = (load_val == '0) ? ONE : load_val;
    end else if (run && !expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sfifo_rd_ctrl.sv
// Phase sequencer: select/address setup, enable lead, strobe, release.
module sfifo_rd_ctrl
  import sfifo_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       setup_done,
  input  logic       words_left,
  input  logic       words_last,
  input  logic       fifo_empty,
  input  logic       slot_free,
  output logic       accept,
  output logic       in_setup,
  output logic       rd_fire,
  output logic       sel,
  output logic       oe,
  output logic       done,
  output logic       idle
);

  seq_state_e state_q, state_d;

  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle && cmd_valid;
  assign in_setup = (state_q == ST_SETUP);
  assign rd_fire  = (state_q == ST_READ) && words_left && !fifo_empty && slot_free;
  assign oe       = (state_q == ST_OE) || (state_q == ST_READ) || (state_q == ST_RDOFF);
  assign sel      = in_setup || oe;
  assign done     = (state_q == ST_HOLD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid)  state_d = ST_SETUP;
      ST_SETUP: if (setup_done) state_d = ST_OE;
      ST_OE:                    state_d = ST_READ;
      ST_READ: begin
        if ((rd_fire && words_last) || !words_left || fifo_empty) begin
          state_d = ST_RDOFF;
        end
      end
      ST_RDOFF:                 state_d = ST_HOLD;
      ST_HOLD:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sfifo_rd_track.sv
// Address hold, word counters and one-deep output capture register.
module sfifo_rd_track #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] fifo_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              words_left,
  output logic              words_last,
  output logic              slot_free,
  output logic [CNT_W-1:0]  xfer_count
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [CNT_W-1:0]  xfer_q, xfer_d;
  logic              cnt_en;
  logic              vld_q, vld_d, vld_en;
  logic [DATA_W-1:0] data_q;

  assign fifo_addr  = addr_q;
  assign out_valid  = vld_q;
  assign out_data   = data_q;
  assign xfer_count = xfer_q;
  assign words_left = (left_q != '0);
  assign words_last = (left_q == CNT_ONE);
  assign slot_free  = !vld_q || out_ready;

  always_comb begin
    cnt_en = accept || rd_fire;
    if (accept) begin
      left_d = cmd_count;
      xfer_d = '0;
    end else begin
      left_d = left_q - CNT_ONE;
      xfer_d = xfer_q + CNT_ONE;
    end
    vld_en = rd_fire || (vld_q && out_ready);
    vld_d  = rd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= cmd_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      xfer_q <= '0;
    end else if (cnt_en) begin
      left_q <= left_d;
      xfer_q <= xfer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (vld_en) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_fire) begin
      data_q <= fifo_data;
    end
  end

endmodule

// File: rtl/sfifo_rd_seq.sv
module sfifo_rd_seq #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int SETUP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [CNT_W-1:0]   cmd_count,
  output logic [ADDR_W-1:0]  fifo_addr,
  output logic               fifo_sel,
  output logic               fifo_oe,
  output logic               fifo_rd,
  input  logic [DATA_W-1:0]  fifo_data,
  input  logic               fifo_empty,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               done_valid,
  output logic [CNT_W-1:0]   done_count
);

  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  logic accept, in_setup, rd_fire, setup_done;
  logic words_left, words_last, slot_free, idle;
  logic [CNT_W-1:0] xfer_count;

  sfifo_rd_timer #(.SETUP_W(SETUP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (accept),
    .load_val (cfg_setup),
    .run      (in_setup),
    .expired  (setup_done)
  );

  sfifo_rd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cmd_valid  (cmd_valid),
    .setup_done (setup_done),
    .words_left (words_left),
    .words_last (words_last),
    .fifo_empty (fifo_empty),
    .slot_free  (slot_free),
    .accept     (accept),
    .in_setup   (in_setup),
    .rd_fire    (rd_fire),
    .sel        (fifo_sel),
    .oe         (fifo_oe),
    .done       (done_valid),
    .idle       (idle)
  );

  sfifo_rd_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .accept     (accept),
    .cmd_addr   (cmd_addr),
    .cmd_count  (cmd_count),
    .rd_fire    (rd_fire),
    .fifo_data  (fifo_data),
    .out_ready  (out_ready),
    .fifo_addr  (fifo_addr),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .words_left (words_left),
    .words_last (words_last),
    .slot_free  (slot_free),
    .xfer_count (xfer_count)
  );

  assign fifo_rd    = rd_fire;
  assign cmd_ready  = idle;
  assign done_count = xfer_count;

endmodule

// File: rtl/sfifo_rd_seq_chk.sv
module sfifo_rd_seq_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fifo_addr,
  input logic              fifo_sel,
  input logic              fifo_oe,
  input logic              fifo_rd,
  input logic              fifo_empty,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              done_valid
);

  assert_rd_needs_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_oe);

  assert_oe_leads_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_rd) |-> $past(fifo_oe));

  assert_rd_needs_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_sel);

  assert_rd_off_before_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_oe) |-> !$past(fifo_rd));

  assert_sel_oe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_sel) |-> $fell(fifo_oe));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_rd_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !fifo_rd);

  assert_no_rd_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fifo_sel) |-> $stable(fifo_addr));

  assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (!fifo_sel && !fifo_oe));

endmodule

bind sfifo_rd_seq sfifo_rd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_addr  (fifo_addr),
  .fifo_sel   (fifo_sel),
  .fifo_oe    (fifo_oe),
  .fifo_rd    (fifo_rd),
  .fifo_empty (fifo_empty),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .done_valid (done_valid)
);

// File: tb/sfifo_rd_seq_tb.sv
`timescale 1ns/1ps
module sfifo_rd_seq_tb;

  localparam int ADDR_W = 2, DATA_W = 16, CNT_W = 8, SETUP_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [SETUP_W-1:0] cfg_setup = '0;
  logic               cmd_valid = 1'b0;
  logic               cmd_ready;
  logic [ADDR_W-1:0]  cmd_addr = '0;
  logic [CNT_W-1:0]   cmd_count = '0;
  logic [ADDR_W-1:0]  fifo_addr;
  logic               fifo_sel, fifo_oe, fifo_rd;
  logic [DATA_W-1:0]  fifo_data;
  logic               fifo_empty;
  logic               out_valid;
  logic               out_ready;
  logic [DATA_W-1:0]  out_data;
  logic               done_valid;
  logic [CNT_W-1:0]   done_count;

  sfifo_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SETUP_W(SETUP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .fifo_addr(fifo_addr), .fifo_sel(fifo_sel), .fifo_oe(fifo_oe), .fifo_rd(fifo_rd),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done_valid(done_valid), .done_count(done_count)
  );

  int total = 0, bad = 0, cyc = 0;

  // FIFO model: prefetched word at pointer, pointer moves on each read edge
  logic        fifo_clr = 1'b0;
  int          fifo_level = 0;
  int          fifo_base = 0;
  int          ptr = 0;
  assign fifo_empty = (ptr >= fifo_level);
  assign fifo_data  = fifo_oe ? DATA_W'(fifo_base + ptr * 3) : '0;
  always @(posedge clk) begin
    if (fifo_clr) ptr <= 0;
    else if (fifo_rd && fifo_sel && !fifo_empty) ptr <= ptr + 1;
  end

  // Downstream readiness pattern
  int rdy_mode = 0;
  int ph = 0;
  always @(posedge clk) ph <= ph + 1;
  assign out_ready = (rdy_mode == 0) ? 1'b1 : ((ph % 3) != 0);

  // Monitor, sampled on the falling edge
  logic mon_clr = 1'b0;
  int viol, rd_cycles, run, max_run, setup_meas, oe_gap, sel_rise, oe_rise, first_rd;
  int got_n, done_seen, done_cnt;
  logic [DATA_W-1:0] got [0:63];
  logic p_rd, p_oe, p_sel, p_v, p_r;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_d;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      viol <= 0; rd_cycles <= 0; run <= 0; max_run <= 0; setup_meas <= -1; oe_gap <= -1;
      first_rd <= 1; got_n <= 0; done_seen <= 0; done_cnt <= -1;
    end else if (rst_n) begin
      if (fifo_sel && !p_sel) sel_rise <= cyc;
      if (fifo_oe && !p_oe) begin oe_rise <= cyc; setup_meas <= cyc - sel_rise; end
      if (fifo_rd && first_rd) begin first_rd <= 0; oe_gap <= cyc - oe_rise; end
      if (fifo_rd) begin rd_cycles <= rd_cycles + 1; run <= run + 1;
                         if (run + 1 > max_run) max_run <= run + 1; end
      else run <= 0;
      if ((fifo_rd && (!fifo_oe || !fifo_sel || fifo_empty)) ||
          (p_oe && !fifo_oe && p_rd) || (fifo_oe != fifo_sel && !(fifo_sel && !fifo_oe)) ||
          (p_sel && fifo_addr != p_addr) ||
          (p_v && !p_r && (!out_valid || out_data != p_d)) ||
          (out_valid && !out_ready && fifo_rd))
        viol <= viol + 1;
      if (out_valid && out_ready && got_n < 64) begin got[got_n] <= out_data; got_n <= got_n + 1; end
      if (done_valid) begin done_seen <= done_seen + 1; done_cnt <= int'(done_count); end
    end
    p_rd <= fifo_rd; p_oe <= fifo_oe; p_sel <= fifo_sel; p_addr <= fifo_addr;
    p_v <= out_valid; p_r <= out_ready; p_d <= out_data;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input int addr, input int count, input int setup,
                         input int level, input int base, input int mode);
    @(posedge clk); #1;
    fifo_clr = 1'b1; mon_clr = 1'b1; fifo_level = level; fifo_base = base; rdy_mode = mode;
    @(posedge clk); #1;
    fifo_clr = 1'b0; mon_clr = 1'b0;
    cmd_addr = ADDR_W'(addr); cmd_count = CNT_W'(count); cfg_setup = SETUP_W'(setup);
    cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int i = 0; i < 400 && done_seen == 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic check_words(input string req, input int n, input int base);
    chk(got_n == n, req, got_n, n);
    for (int i = 0; i < n && i < got_n; i++)
      chk(got[i] == DATA_W'(base + i * 3), req, int'(got[i]), base + i * 3);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
    chk({fifo_sel, fifo_oe, fifo_rd} == 3'b000, "R1 strobes idle", int'({fifo_sel, fifo_oe, fifo_rd}), 0);
    chk(!out_valid && !done_valid, "R1 outputs idle", int'({out_valid, done_valid}), 0);
  endtask

  task automatic t_single();
    run_txn(1, 1, 2, 5, 16'h1200, 0);
    chk(rd_cycles == 1, "R7 single strobe", rd_cycles, 1);
    check_words("R6 single word", 1, 16'h1200);
    chk(done_cnt == 1, "R10 single done count", done_cnt, 1);
    chk(setup_meas == 2, "R2 default setup", setup_meas, 2);
    chk(viol == 0, "R3/R4/R9 single ordering", viol, 0);
  endtask

  task automatic t_burst();
    run_txn(2, 8, 2, 16, 16'h4000, 0);
    chk(max_run == 8 && rd_cycles == 8, "R5 continuous strobe", max_run, 8);
    check_words("R5 burst order", 8, 16'h4000);
    chk(oe_gap == 1, "R3 enable lead", oe_gap, 1);
    chk(done_cnt == 8 && done_seen == 1, "R10 burst done", done_cnt, 8);
    chk(viol == 0, "R4 R9 burst ordering", viol, 0);
  endtask

  task automatic t_setup();
    run_txn(3, 2, 5, 8, 16'h0700, 0);
    chk(setup_meas == 5, "R2 setup 5", setup_meas, 5);
    run_txn(0, 2, 0, 8, 16'h0800, 0);
    chk(setup_meas == 1, "R2 setup 0 clamps", setup_meas, 1);
    check_words("R2 data after min setup", 2, 16'h0800);
  endtask

  task automatic t_backpressure();
    run_txn(1, 12, 2, 20, 16'h2100, 1);
    check_words("R6 stalled stream", 12, 16'h2100);
    chk(rd_cycles == 12, "R6 strobe count", rd_cycles, 12);
    chk(viol == 0, "R6 hold and pause", viol, 0);
  endtask

  task automatic t_empty();
    run_txn(2, 10, 2, 3, 16'h3300, 0);
    chk(done_cnt == 3, "R8 early stop count", done_cnt, 3);
    chk(rd_cycles == 3, "R8 no strobe when empty", rd_cycles, 3);
    check_words("R8 words before empty", 3, 16'h3300);
    run_txn(1, 4, 2, 0, 16'h0100, 0);
    chk(rd_cycles == 0 && done_cnt == 0, "R8 empty at start", done_cnt, 0);
  endtask

  task automatic t_zero();
    run_txn(0, 0, 2, 8, 16'h5000, 0);
    chk(rd_cycles == 0, "R7 zero count strobe", rd_cycles, 0);
    chk(done_cnt == 0 && done_seen == 1, "R7 zero count done", done_cnt, 0);
    chk(cmd_ready == 1'b1, "R10 ready after done", int'(cmd_ready), 1);
  endtask

  initial begin
    mon_clr = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_clr = 1'b0;
    t_reset();
    t_single();
    t_burst();
    t_setup();
    t_backpressure();
    t_empty();
    t_zero();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule